// File: doc/BRIEF.md
# Vector length configuration unit

This block decides how many lanes of a vector unit may run at once when all lanes draw their registers from one shared physical pool of integer registers and one of floating-point registers. Software first configures how many registers of each kind a single lane needs. The unit then divides each pool, less one register, by the per-lane need, less one. It keeps the smaller of the two results and caps it at the number of hardware lanes. The result is the maximum vector length. A later set-length request asks for an application vector length and is granted the smaller of that request and the current maximum.

Both requests arrive on valid/ready channels. A channel transfers on a rising clock edge where its valid and ready are both high. Once valid is raised, the requester keeps it and its data steady until the transfer. Nothing is captured while ready is low. The divisions run on serial restoring dividers, one per register kind, and both dividers work in parallel. While they run, the unit holds `busy` high and drops both ready signals, which applies back-pressure to new configurations and to set-length requests. When the new maximum is in place, `done` pulses for one cycle. The granted length is a plain output register and needs no handshake.

Top module: `vlen_cfg_unit`

## Requirements
- R1: After reset, max_vl is 8 (or NUM_LANES if fewer lanes exist), cur_vl is 0, busy and done are 0, and both cfg_ready and req_ready are 1.
- R2: A configuration with both usage counts 0 sets max_vl to 8, capped at NUM_LANES.
- R3: With fp usage 0 and integer usage u of 2 or more, max_vl is floor((INT_REGS_TOTAL-1)/(u-1)), capped at NUM_LANES; for example, u=9 gives 31, u=256 gives 1 and u=300 gives 0.
- R4: With integer usage 0 and fp usage f of 2 or more, max_vl is floor((FP_REGS_TOTAL-1)/(f-1)), capped at NUM_LANES; for example, f=33 gives 7.
- R5: With both usages 2 or more, max_vl is the smaller of the two quotients, capped at NUM_LANES.
- R6: max_vl never exceeds NUM_LANES; a quotient above it yields NUM_LANES.
- R7: A usage count of exactly 1 places no bound from that register kind, so only the other kind and the lane cap limit max_vl.
- R8: A set-length transfer loads cur_vl with min(max_vl, req_len), visible from the clock edge of the transfer.
- R9: busy rises on the edge of a configuration transfer and stays high for exactly DIV_W+1 cycles, where DIV_W is the larger of USE_W and the bit width of the larger register total less one (10 cycles with defaults). max_vl holds during busy and takes its new value on the edge where busy falls. On that same edge done rises for exactly one cycle.
- R10: While busy, cfg_ready and req_ready are 0, and a set-length request offered then leaves cur_vl unchanged.
- R11: When a configuration and a set-length request transfer on the same edge, the grant uses the max_vl that held before that configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration request valid |
| cfg_ready | output | 1 | Configuration can be accepted (low while busy) |
| cfg_int_use | input | USE_W | Integer registers used per lane |
| cfg_fp_use | input | USE_W | Floating-point registers used per lane |
| req_valid | input | 1 | Set-length request valid |
| req_ready | output | 1 | Set-length request can be accepted (low while busy) |
| req_len | input | LEN_W | Requested application vector length |
| max_vl | output | VL_W | Current maximum vector length |
| cur_vl | output | VL_W | Granted vector length |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when a new max_vl is in place |

## Verification
On every cycle, the assertions check the handshake and timing rules. They check that ready is low while busy and that busy lasts no longer than its fixed window. They also check that done is a single pulse that follows busy falling, that max_vl holds while busy, that every grant equals the minimum of the request and the prior maximum, and that max_vl never exceeds the lane count. Only the bench scenarios can show that the quotients themselves are right. That covers the both-zero default, each single-kind case, the minimum over two kinds, the usage-of-one case and the lane cap. The bench scenarios also show that a request offered during busy is held back and that a configuration and a request taken together grant against the old maximum.

// File: rtl/vlc_pkg.sv
package vlc_pkg;

  // Index of each register kind in the per-kind arrays.
  typedef enum int {
    VLC_KIND_INT = 0,
    VLC_KIND_FP  = 1
  } vlc_kind_e;

  localparam int VLC_NUM_KINDS = 2;

  // Maximum length when no register kind is in use.
  localparam int VLC_IDLE_LIMIT = 8;

  function automatic int vlc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int vlc_min(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/vlc_restoring_div.sv
// Serial restoring divider: one quotient bit per cycle, W cycles per division.
module vlc_restoring_div #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         running_o,
  output logic [W-1:0] quotient_o
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     rem_q;
  logic [W-1:0]     quo_q;
  logic [W-1:0]     dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [W:0]   shifted;
  logic         fits;
  logic [W-1:0] rem_sub;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    fits    = (shifted >= {1'b0, dsr_q});
    rem_sub = shifted[W-1:0] - dsr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      quo_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      rem_q <= '0;
      quo_q <= dividend_i;
      dsr_q <= divisor_i;
      cnt_q <= CNT_W'(W);
      run_q <= 1'b1;
    end else if (run_q) begin
      rem_q <= fits ? rem_sub : shifted[W-1:0];
      quo_q <= {quo_q[W-2:0], fits};
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
      end
    end
  end

  assign running_o  = run_q;
  assign quotient_o = quo_q;

endmodule

// File: rtl/vlc_limit_select.sv
// Combines the per-kind quotients into one limit, capped at the lane count.
module vlc_limit_select
  import vlc_pkg::*;
#(
  parameter int NUM_LANES = 32,
  parameter int USE_W     = 9,
  parameter int DIV_W     = 9,
  parameter int VL_W      = 6
) (
  input  logic [VLC_NUM_KINDS-1:0][USE_W-1:0] use_i,
  input  logic [VLC_NUM_KINDS-1:0][DIV_W-1:0] quo_i,
  output logic [VL_W-1:0]                     limit_o
);
  localparam int CMP_W     = vlc_max(DIV_W, VL_W);
  localparam int IDLE_LIM  = vlc_min(VLC_IDLE_LIMIT, NUM_LANES);

  logic             any_used;
  logic [CMP_W-1:0] cand;

  always_comb begin
    any_used = 1'b0;
    cand     = CMP_W'(NUM_LANES);
    for (int k = 0; k < VLC_NUM_KINDS; k++) begin
      if (use_i[k] != '0) begin
        any_used = 1'b1;
        // A usage of one means a zero divisor: that kind sets no bound.
        if ((use_i[k] != USE_W'(1)) && (CMP_W'(quo_i[k]) < cand)) begin
          cand = CMP_W'(quo_i[k]);
        end
      end
    end
    limit_o = any_used ? VL_W'(cand) : VL_W'(IDLE_LIM);
  end

endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit
  import vlc_pkg::*;
#(
  parameter int NUM_LANES      = 32,
  parameter int INT_REGS_TOTAL = 256,
  parameter int FP_REGS_TOTAL  = 256,
  parameter int USE_W          = 9,
  parameter int LEN_W          = 16,
  parameter int VL_W           = $clog2(NUM_LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_valid,
  output logic             cfg_ready,
  input  logic [USE_W-1:0] cfg_int_use,
  input  logic [USE_W-1:0] cfg_fp_use,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [LEN_W-1:0] req_len,
  output logic [VL_W-1:0]  max_vl,
  output logic [VL_W-1:0]  cur_vl,
  output logic             busy,
  output logic             done
);
  localparam int TOT_MAX  = vlc_max(INT_REGS_TOTAL, FP_REGS_TOTAL);
  localparam int TOT_W    = vlc_max($clog2(TOT_MAX), 2);
  localparam int DIV_W    = vlc_max(USE_W, TOT_W);
  localparam int GRANT_W  = vlc_max(LEN_W, VL_W);
  localparam int IDLE_LIM = vlc_min(VLC_IDLE_LIMIT, NUM_LANES);

  logic                                busy_q;
  logic                                done_q;
  logic [VL_W-1:0]                     max_q;
  logic [VL_W-1:0]                     cur_q;
  logic [VLC_NUM_KINDS-1:0][USE_W-1:0] use_q;
  logic [VLC_NUM_KINDS-1:0][USE_W-1:0] use_in;
  logic [VLC_NUM_KINDS-1:0][DIV_W-1:0] quo;
  logic [VLC_NUM_KINDS-1:0]            div_run;
  logic [VL_W-1:0]                     limit;
  logic [VL_W-1:0]                     grant;
  logic                                cfg_fire;
  logic                                req_fire;
  logic                                finish;

  assign use_in[VLC_KIND_INT] = cfg_int_use;
  assign use_in[VLC_KIND_FP]  = cfg_fp_use;

  assign cfg_fire = cfg_valid && !busy_q;
  assign req_fire = req_valid && !busy_q;
  assign finish   = busy_q && (div_run == '0);

  // One serial divider per register kind, started together.
  for (genvar k = 0; k < VLC_NUM_KINDS; k++) begin : g_kind
    localparam int TOTAL = (k == VLC_KIND_INT) ? INT_REGS_TOTAL : FP_REGS_TOTAL;
    logic [DIV_W-1:0] dsr;
    assign dsr = DIV_W'(use_in[k]) - DIV_W'(1);

    vlc_restoring_div #(.W(DIV_W)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (cfg_fire),
      .dividend_i(DIV_W'(TOTAL - 1)),
      .divisor_i (dsr),
      .running_o (div_run[k]),
      .quotient_o(quo[k])
    );
  end

  vlc_limit_select #(
    .NUM_LANES(NUM_LANES),
    .USE_W    (USE_W),
    .DIV_W    (DIV_W),
    .VL_W     (VL_W)
  ) u_sel (
    .use_i  (use_q),
    .quo_i  (quo),
    .limit_o(limit)
  );

  always_comb begin
    if (GRANT_W'(req_len) < GRANT_W'(max_q)) begin
      grant = VL_W'(req_len);
    end else begin
      grant = max_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      max_q  <= VL_W'(IDLE_LIM);
      cur_q  <= '0;
      use_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (cfg_fire) begin
        busy_q <= 1'b1;
        use_q  <= use_in;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        max_q  <= limit;
      end
      if (req_fire) begin
        cur_q <= grant;
      end
    end
  end

  assign cfg_ready = !busy_q;
  assign req_ready = !busy_q;
  assign max_vl    = max_q;
  assign cur_vl    = cur_q;
  assign busy      = busy_q;
  assign done      = done_q;

endmodule

// File: rtl/vlc_checker.sv
module vlc_checker #(
  parameter int NUM_LANES = 32,
  parameter int LEN_W     = 16,
  parameter int VL_W      = 6,
  parameter int DIV_W     = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_valid,
  input logic             cfg_ready,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic [VL_W-1:0]  max_vl,
  input logic [VL_W-1:0]  cur_vl,
  input logic             busy,
  input logic             done
);
  localparam int GW = (LEN_W > VL_W) ? LEN_W : VL_W;

  int unsigned busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      busy_len <= 0;
    end else begin
      busy_len <= busy_len + 1;
    end
  end

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!cfg_ready && !req_ready)); // R10

  AST_CFG_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_ready) |=> busy); // R9

  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_len <= DIV_W + 1); // R9

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_ON_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R9

  AST_MAX_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || $stable(max_vl))); // R9

  AST_MAX_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    int'(max_vl) <= NUM_LANES); // R6

  AST_GRANT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=>
      (GW'(cur_vl) == ((GW'($past(req_len)) < GW'($past(max_vl))) ?
                       GW'($past(req_len)) : GW'($past(max_vl))))); // R8

  AST_CUR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(cur_vl)); // R10

endmodule

bind vlen_cfg_unit vlc_checker #(
  .NUM_LANES(NUM_LANES),
  .LEN_W    (LEN_W),
  .VL_W     (VL_W),
  .DIV_W    (DIV_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_valid(cfg_valid),
  .cfg_ready(cfg_ready),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_len  (req_len),
  .max_vl   (max_vl),
  .cur_vl   (cur_vl),
  .busy     (busy),
  .done     (done)
);

// File: tb/vlen_cfg_unit_tb.sv
module vlen_cfg_unit_tb;
  localparam int CLK_NS    = 4;
  localparam int USE_W     = 9;
  localparam int LEN_W     = 16;
  localparam int VL_W      = 6;
  localparam int BUSY_LEN  = 10;
  localparam int NROWS     = 15;

  // {integer usage, fp usage, expected max_vl}; 256 registers per kind, 32 lanes.
  localparam logic [23:0] VEC [NROWS] = '{
    {9'd0,   9'd0,  6'd8},   // R2
    {9'd9,   9'd0,  6'd31},  // R3
    {9'd17,  9'd0,  6'd15},  // R3
    {9'd256, 9'd0,  6'd1},   // R3
    {9'd300, 9'd0,  6'd0},   // R3
    {9'd0,   9'd33, 6'd7},   // R4
    {9'd0,   9'd5,  6'd32},  // R4 with R6 cap
    {9'd2,   9'd0,  6'd32},  // R6
    {9'd1,   9'd0,  6'd32},  // R7
    {9'd0,   9'd1,  6'd32},  // R7
    {9'd1,   9'd1,  6'd32},  // R7
    {9'd1,   9'd33, 6'd7},   // R7
    {9'd17,  9'd9,  6'd15},  // R5
    {9'd33,  9'd9,  6'd7},   // R5
    {9'd9,   9'd17, 6'd15}   // R5
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_valid = 1'b0;
  logic             cfg_ready;
  logic [USE_W-1:0] cfg_int_use = '0;
  logic [USE_W-1:0] cfg_fp_use = '0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [LEN_W-1:0] req_len = '0;
  logic [VL_W-1:0]  max_vl;
  logic [VL_W-1:0]  cur_vl;
  logic             busy;
  logic             done;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_NS / 2) clk = ~clk;

  vlen_cfg_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_valid  (cfg_valid),
    .cfg_ready  (cfg_ready),
    .cfg_int_use(cfg_int_use),
    .cfg_fp_use (cfg_fp_use),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_len    (req_len),
    .max_vl     (max_vl),
    .cur_vl     (cur_vl),
    .busy       (busy),
    .done       (done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Sends one configuration and waits until busy falls; returns busy length.
  task automatic run_cfg(input int iu, input int fu, output int nbusy);
    @(negedge clk);
    cfg_valid   = 1'b1;
    cfg_int_use = USE_W'(iu);
    cfg_fp_use  = USE_W'(fu);
    @(negedge clk);
    cfg_valid = 1'b0;
    nbusy = 0;
    while (busy && nbusy < 100) begin
      nbusy++;
      @(negedge clk);
    end
  endtask

  task automatic run_setvl(input int len, input int exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = LEN_W'(len);
    @(negedge clk);
    req_valid = 1'b0;
    check(tag, int'(cur_vl), exp);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 max_vl", int'(max_vl), 8);
    check("R1 cur_vl", int'(cur_vl), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 ready", int'(cfg_ready && req_ready), 1);

    // R8 grants against the reset maximum
    run_setvl(5, 5, "R8 below max");
    run_setvl(20, 8, "R8 above max");

    // Table walk: R2..R7 quotient rules, with R9 timing on each row
    for (int i = 0; i < NROWS; i++) begin
      run_cfg(int'(VEC[i][23:15]), int'(VEC[i][14:6]), nb);
      check($sformatf("row %0d max_vl", i), int'(max_vl), int'(VEC[i][5:0]));
      check($sformatf("R9 row %0d busy length", i), nb, BUSY_LEN);
      check($sformatf("R9 row %0d done pulse", i), int'(done), 1);
      @(negedge clk);
      check($sformatf("R9 row %0d done clears", i), int'(done), 0);
    end

    // R8 after the last configuration (max 15)
    run_setvl(100, 15, "R8 clip to max");
    run_setvl(3, 3, "R8 small request");

    // R10: request offered during busy is held back
    begin
      int seen_ready;
      seen_ready = 0;
      @(negedge clk);
      cfg_valid   = 1'b1;
      cfg_int_use = USE_W'(33);
      cfg_fp_use  = USE_W'(9);
      @(negedge clk);
      cfg_valid = 1'b0;
      req_valid = 1'b1;
      req_len   = LEN_W'(1);
      while (busy) begin
        if (cfg_ready || req_ready) seen_ready = 1;
        @(negedge clk);
      end
      req_valid = 1'b0;
      check("R10 ready low while busy", seen_ready, 0);
      check("R10 cur_vl unchanged", int'(cur_vl), 3);
      check("R10 new max", int'(max_vl), 7);
    end

    // R11: configuration and request on the same edge use the old max
    @(negedge clk);
    cfg_valid   = 1'b1;
    cfg_int_use = USE_W'(2);
    cfg_fp_use  = USE_W'(0);
    req_valid   = 1'b1;
    req_len     = LEN_W'(40);
    @(negedge clk);
    cfg_valid = 1'b0;
    req_valid = 1'b0;
    check("R11 grant uses old max", int'(cur_vl), 7);
    while (busy) @(negedge clk);
    check("R11 max after cfg", int'(max_vl), 32);
    run_setvl(40, 32, "R8 grant at lane cap");
    run_setvl(0, 0, "R8 zero request");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule